// File: doc/BRIEF.md
# Half-Cycle Bus Cycle Sequencer for an 8-bit CPU

This block produces the control strobes of a classic 8-bit processor bus for one machine cycle at a time. Its clock runs at twice the processor clock rate, so every clock tick is one half cycle of the processor bus. The processor core supplies a cycle type, an address and write data through a request port. The sequencer then drives the address, the data-out enable and the active-low memory request, I/O request, read, write, first-opcode-cycle and refresh strobes with timing exact to the half cycle. It samples an active-low wait input at the end of the start phase, captures read data, and pulses `done` in the last half cycle.

Six cycle kinds are supported: opcode fetch followed by a refresh window, memory read, memory write, I/O input, I/O output and an internal cycle that drives no strobes. Between machine cycles an external master can take the bus with an active-low bus request. The sequencer then lowers its output enable and acknowledges until the request is withdrawn.

Top module: `zbus_cycle_seq`

## Requirements
- R1: After reset the block is idle: every strobe output is high, `busack_n` is high, `bus_oe` is 1, `req_ready` is 1 and `done` is 0.
- R2: A fetch (`req_type`=1) asserts only `m1_n` in half 0. From half 1 it asserts `m1_n`, `mreq_n` and `rd_n` together through the end of the fetch part, which is two halves after the wait sampling point. `addr` carries the requested address during the fetch part.
- R3: The 8-half refresh window after a fetch holds `rfsh_n` low throughout. `mreq_n` is low in refresh halves 0, 2 and 3 only. `addr` carries `i_page` in bits 15:8, 0 in bit 7 and a 7-bit counter in bits 6:0. The counter starts at 0 after reset and advances by one after each fetch.
- R4: A memory read (`req_type`=2) drives no strobe in half 0. `mreq_n` and `rd_n` are low from half 1 through the next-to-last half, and all strobes are high in the last half.
- R5: A memory write (`req_type`=3) holds only `mreq_n` low from half 1 through any wait halves. `wr_n` goes low only in the two halves after wait sampling, and all strobes are high in the last half. `dout_en` is 1 and `dout` equals the write data until the last half.
- R6: I/O input (`req_type`=4) and output (`req_type`=5) drive no strobe in halves 0 and 1. `iorq_n` is low with `rd_n` (input) or `wr_n` (output) from half 2 through the next-to-last half.
- R7: `wait_n` is sampled at the end of half 2 and at the end of each inserted wait clock. Each low sample inserts two more halves that hold the half-2 strobe pattern.
- R8: On read, input and fetch cycles, `rdata` holds `din` when `din_driven` is 1 and 0xFF otherwise. The value is captured in the half before the last bus half and holds until the next such cycle.
- R9: An internal cycle (`req_type` 0, and the unused codes 6 and 7) lasts INT_HALVES halves and drives no strobes.
- R10: A low `busreq_n` is granted only from idle. While granted, `busack_n` is low, `bus_oe` is 0, `req_ready` is 0, no strobe is driven and requests are ignored. A request arriving during a cycle is granted only after `done`.
- R11: `done` is high for exactly one tick, in the last half of every cycle. `req_ready` is high only while idle with the bus not requested.
- R12: `rd_n` and `wr_n` are never low together, and neither are `mreq_n` and `iorq_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle clock (twice the processor clock rate) |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request a machine cycle |
| req_ready | output | 1 | Block is idle and takes a request this tick |
| req_type | input | 3 | Cycle kind: 0 internal, 1 fetch, 2 read, 3 write, 4 input, 5 output |
| req_addr | input | 16 | Address of the cycle |
| req_wdata | input | 8 | Data for write and output cycles |
| i_page | input | 8 | Upper byte of the refresh address |
| wait_n | input | 1 | Active-low wait request |
| busreq_n | input | 1 | Active-low bus request from another master |
| busack_n | output | 1 | Active-low bus grant |
| din | input | 8 | Data bus input |
| din_driven | input | 1 | A device drives the data bus |
| addr | output | 16 | Address bus |
| dout | output | 8 | Data bus output |
| dout_en | output | 1 | Data output enable |
| bus_oe | output | 1 | Enable for address and strobe drivers |
| mreq_n | output | 1 | Memory request |
| iorq_n | output | 1 | I/O request |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe |
| m1_n | output | 1 | First opcode cycle marker |
| rfsh_n | output | 1 | Refresh strobe |
| done | output | 1 | Last half of the cycle |
| rdata | output | 8 | Captured read data |

## Verification
The assertions check, on every tick, the properties that hold regardless of cycle kind. These are strobe exclusivity, the single-tick `done` pulse, quiet strobes while idle or granted, that refresh excludes read, write and M1, and that a memory write strobe is always preceded by an active memory request. Only the bench scenarios can show the exact half-by-half shape of each cycle kind. They also show how wait samples stretch a cycle, the refresh address and counter sequence, the 0xFF default of an undriven bus, and the deferral of a bus request that arrives in mid-cycle.

// File: rtl/zbus_pkg.sv
package zbus_pkg;

    typedef enum logic [2:0] {
        CYC_INTERNAL = 3'd0,
        CYC_FETCH    = 3'd1,
        CYC_READ     = 3'd2,
        CYC_WRITE    = 3'd3,
        CYC_IN       = 3'd4,
        CYC_OUT      = 3'd5
    } cyc_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_WAIT,
        PH_COMP,
        PH_RFSH,
        PH_INT,
        PH_GRANT
    } phase_e;

    // active-high strobe set; inverted at the pins
    typedef struct packed {
        logic m1;
        logic mreq;
        logic iorq;
        logic rd;
        logic wr;
        logic rfsh;
    } strobe_t;

endpackage

// File: rtl/zbus_strobe_dec.sv
module zbus_strobe_dec
    import zbus_pkg::*;
#(
    parameter int CW = 3
) (
    input  phase_e          phase,
    input  cyc_e            cyc,
    input  logic [CW-1:0]   cnt,
    output strobe_t         stb
);
    logic is_mem, is_io, rd_kind, wr_kind;

    always_comb begin
        is_mem  = (cyc == CYC_FETCH) || (cyc == CYC_READ) || (cyc == CYC_WRITE);
        is_io   = (cyc == CYC_IN) || (cyc == CYC_OUT);
        rd_kind = (cyc == CYC_FETCH) || (cyc == CYC_READ) || (cyc == CYC_IN);
        wr_kind = (cyc == CYC_WRITE) || (cyc == CYC_OUT);
        stb     = '0;
        case (phase)
            PH_START: begin
                stb.m1 = (cyc == CYC_FETCH);
                if (is_mem && cnt != '0) begin
                    stb.mreq = 1'b1;
                    stb.rd   = rd_kind;
                end
                if (is_io && cnt == CW'(2)) begin
                    stb.iorq = 1'b1;
                    stb.rd   = rd_kind;
                    stb.wr   = (cyc == CYC_OUT);
                end
            end
            PH_WAIT: begin
                stb.m1   = (cyc == CYC_FETCH);
                stb.mreq = is_mem;
                stb.iorq = is_io;
                stb.rd   = rd_kind;
                stb.wr   = (cyc == CYC_OUT);
            end
            PH_COMP: begin
                if (cnt <= CW'(1)) begin
                    stb.m1   = (cyc == CYC_FETCH);
                    stb.mreq = is_mem;
                    stb.iorq = is_io;
                    stb.rd   = rd_kind;
                    stb.wr   = wr_kind;
                end
            end
            PH_RFSH: begin
                stb.rfsh = 1'b1;
                stb.mreq = (cnt == CW'(0)) || (cnt == CW'(2)) || (cnt == CW'(3));
            end
            default: stb = '0;
        endcase
    end
endmodule

// File: rtl/zbus_refresh_ctr.sv
module zbus_refresh_ctr #(
    parameter int RW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    output logic [RW-1:0] value
);
    logic [RW-1:0] value_d, value_q;

    always_comb value_d = inc ? value_q + RW'(1) : value_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) value_q <= '0;
        else        value_q <= value_d;
    end

    assign value = value_q;
endmodule

// File: rtl/zbus_cycle_seq.sv
module zbus_cycle_seq
    import zbus_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DW         = 8,
    parameter int IW         = 8,
    parameter int RW         = 7,
    parameter int INT_HALVES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [2:0]    req_type,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [IW-1:0] i_page,
    input  logic          wait_n,
    input  logic          busreq_n,
    output logic          busack_n,
    input  logic [DW-1:0] din,
    input  logic          din_driven,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    output logic          bus_oe,
    output logic          mreq_n,
    output logic          iorq_n,
    output logic          rd_n,
    output logic          wr_n,
    output logic          m1_n,
    output logic          rfsh_n,
    output logic          done,
    output logic [DW-1:0] rdata
);
    localparam int MAXC = (INT_HALVES > 8) ? INT_HALVES : 8;
    localparam int CW   = $clog2(MAXC);
    localparam int LOW  = AW - IW;
    localparam logic [CW-1:0] INT_LAST  = CW'(INT_HALVES - 1);
    localparam logic [CW-1:0] RFSH_LAST = CW'(7);

    typedef struct packed {
        phase_e        phase;
        cyc_e          cyc;
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
    } state_t;

    state_t        st_d, st_q;
    cyc_e          req_cyc;
    logic          rfsh_inc;
    logic [RW-1:0] rfsh_cnt;
    strobe_t       stb;

    always_comb begin
        req_cyc = (req_type > 3'd5) ? CYC_INTERNAL : cyc_e'(req_type);
    end

    always_comb begin
        st_d     = st_q;
        done     = 1'b0;
        rfsh_inc = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (!busreq_n) begin
                    st_d.phase = PH_GRANT;
                end else if (req_valid) begin
                    st_d.cyc   = req_cyc;
                    st_d.addr  = req_addr;
                    st_d.wdata = req_wdata;
                    st_d.cnt   = '0;
                    st_d.phase = (req_cyc == CYC_INTERNAL) ? PH_INT : PH_START;
                end
            end
            PH_START: begin
                if (st_q.cnt == CW'(2)) begin
                    st_d.cnt   = '0;
                    st_d.phase = wait_n ? PH_COMP : PH_WAIT;
                end else begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
            end
            PH_WAIT: begin
                if (st_q.cnt == CW'(1)) begin
                    st_d.cnt   = '0;
                    st_d.phase = wait_n ? PH_COMP : PH_WAIT;
                end else begin
                    st_d.cnt = CW'(1);
                end
            end
            PH_COMP: begin
                if (st_q.cnt == CW'(1) && (st_q.cyc == CYC_FETCH ||
                        st_q.cyc == CYC_READ || st_q.cyc == CYC_IN)) begin
                    st_d.rdata = din_driven ? din : '1;
                end
                if (st_q.cyc == CYC_FETCH && st_q.cnt == CW'(1)) begin
                    st_d.cnt   = '0;
                    st_d.phase = PH_RFSH;
                end else if (st_q.cnt == CW'(2)) begin
                    done       = 1'b1;
                    st_d.phase = PH_IDLE;
                end else begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
            end
            PH_RFSH: begin
                if (st_q.cnt == RFSH_LAST) begin
                    done       = 1'b1;
                    rfsh_inc   = 1'b1;
                    st_d.phase = PH_IDLE;
                end else begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
            end
            PH_INT: begin
                if (st_q.cnt == INT_LAST) begin
                    done       = 1'b1;
                    st_d.phase = PH_IDLE;
                end else begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
            end
            PH_GRANT: begin
                if (busreq_n) st_d.phase = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
            st_q.cyc   <= CYC_INTERNAL;
            st_q.rdata <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    zbus_refresh_ctr #(.RW(RW)) u_rctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (rfsh_inc),
        .value (rfsh_cnt)
    );

    zbus_strobe_dec #(.CW(CW)) u_dec (
        .phase (st_q.phase),
        .cyc   (st_q.cyc),
        .cnt   (st_q.cnt),
        .stb   (stb)
    );

    always_comb begin
        addr      = (st_q.phase == PH_RFSH) ?
                    {i_page, {(LOW - RW){1'b0}}, rfsh_cnt} : st_q.addr;
        dout      = st_q.wdata;
        dout_en   = (st_q.cyc == CYC_WRITE || st_q.cyc == CYC_OUT) &&
                    (st_q.phase == PH_START || st_q.phase == PH_WAIT ||
                     (st_q.phase == PH_COMP && st_q.cnt != CW'(2)));
        bus_oe    = (st_q.phase != PH_GRANT);
        busack_n  = (st_q.phase != PH_GRANT);
        req_ready = (st_q.phase == PH_IDLE) && busreq_n;
        m1_n      = ~stb.m1;
        mreq_n    = ~stb.mreq;
        iorq_n    = ~stb.iorq;
        rd_n      = ~stb.rd;
        wr_n      = ~stb.wr;
        rfsh_n    = ~stb.rfsh;
        rdata     = st_q.rdata;
    end

    // R12: strobe exclusivity
    a_r12_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n || wr_n);
    a_r12_mreq_iorq_excl: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_n || iorq_n);
    // R10: bus released while granted
    a_r10_grant_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busack_n |-> (!bus_oe && mreq_n && iorq_n && rd_n && wr_n && rfsh_n));
    a_r10_grant_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busack_n) |-> $past(mreq_n && iorq_n && rfsh_n));
    // R11: done is a single tick, ready only when quiet
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r11_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mreq_n && iorq_n && rd_n && wr_n && rfsh_n && !done));
    // R3: refresh excludes transfer strobes
    a_r3_rfsh_alone: assert property (@(posedge clk) disable iff (!rst_n)
        !rfsh_n |-> (rd_n && wr_n && m1_n && iorq_n));
    // R5: memory write strobe only after memory request already active
    a_r5_wr_after_mreq: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && iorq_n) |-> $past(!mreq_n));
endmodule

// File: tb/zbus_cycle_seq_tb.sv
module zbus_cycle_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_type = 3'd0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  i_page = 8'h3C;
    logic        wait_n = 1'b1;
    logic        busreq_n = 1'b1;
    logic        busack_n;
    logic [7:0]  din = '0;
    logic        din_driven = 1'b0;
    logic [15:0] addr;
    logic [7:0]  dout;
    logic        dout_en, bus_oe;
    logic        mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n, done;
    logic [7:0]  rdata;

    int errors = 0;
    int checks = 0;
    int rcnt_model = 0;

    always #10 clk = ~clk;

    zbus_cycle_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_type(req_type), .req_addr(req_addr), .req_wdata(req_wdata),
        .i_page(i_page), .wait_n(wait_n), .busreq_n(busreq_n), .busack_n(busack_n),
        .din(din), .din_driven(din_driven), .addr(addr), .dout(dout),
        .dout_en(dout_en), .bus_oe(bus_oe), .mreq_n(mreq_n), .iorq_n(iorq_n),
        .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n), .rfsh_n(rfsh_n), .done(done),
        .rdata(rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // {m1,mreq,iorq,rd,wr,rfsh} active-high
    function automatic logic [5:0] exp_pat(input int typ, input int k, input int nw);
        int c;
        logic [5:0] held;
        c = k;
        case (typ)
            1: held = 6'b110100;
            2: held = 6'b010100;
            3: held = 6'b010000;
            4: held = 6'b001100;
            5: held = 6'b001010;
            default: held = 6'b000000;
        endcase
        if (typ == 0 || typ > 5) return 6'b0;
        if (c < 3) begin
            if (c == 0) return (typ == 1) ? 6'b100000 : 6'b0;
            if (c == 1 && typ >= 4) return 6'b0;
            return held;
        end
        c = c - 3;
        if (c < 2 * nw) return held;
        c = c - 2 * nw;
        if (c < 2) return (typ == 3) ? 6'b010010 : held;
        if (typ != 1) return 6'b0;
        c = c - 2;
        return (c == 0 || c == 2 || c == 3) ? 6'b010001 : 6'b000001;
    endfunction

    task automatic run_cycle(input int typ, input logic [15:0] a, input logic [7:0] wd,
                             input int nw, input bit dv, input logic [7:0] dval,
                             input bit mid_breq, input string tag);
        int total, rstart;
        bit pat_ok, rf_ok, done_ok, addr_ok, dout_ok, excl_ok;
        logic [5:0] obs, pa, pe, ra, re;
        logic [15:0] exp_a, aa, ae;
        pat_ok = 1; rf_ok = 1; done_ok = 1; addr_ok = 1; dout_ok = 1; excl_ok = 1;
        pa = '0; pe = '0; ra = '0; re = '0; aa = '0; ae = '0;
        if (typ == 0 || typ > 5) total = 4;
        else if (typ == 1) total = 13 + 2 * nw;
        else total = 6 + 2 * nw;
        rstart = 5 + 2 * nw;
        while (!req_ready) @(negedge clk);
        din = dval; din_driven = dv;
        req_type = 3'(typ); req_addr = a; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < total; k++) begin
            obs = {~m1_n, ~mreq_n, ~iorq_n, ~rd_n, ~wr_n, ~rfsh_n};
            pe = exp_pat(typ, k, nw);
            if (obs != pe) begin
                if (typ == 1 && k >= rstart) begin
                    if (rf_ok) begin ra = obs; re = pe; end
                    rf_ok = 0;
                end else begin
                    if (pat_ok) begin pa = obs; pe = exp_pat(typ, k, nw); end
                    pat_ok = 0;
                end
            end
            if (done !== (k == total - 1)) done_ok = 0;
            if (!rd_n && !wr_n) excl_ok = 0;
            if (!mreq_n && !iorq_n) excl_ok = 0;
            if (busack_n !== 1'b1) done_ok = 0;
            exp_a = (typ == 1 && k >= rstart) ? {i_page, 1'b0, 7'(rcnt_model)} : a;
            if (typ != 0 && typ <= 5 && addr !== exp_a) begin
                if (addr_ok) begin aa = addr; ae = exp_a; end
                addr_ok = 0;
            end
            if ((typ == 3 || typ == 5) && k < total - 1 && (!dout_en || dout !== wd))
                dout_ok = 0;
            wait_n = !(typ != 0 && k >= 2 && k < 2 + 2 * nw);
            if (mid_breq && k == 1) busreq_n = 1'b0;
            @(negedge clk);
        end
        wait_n = 1'b1;
        chk(pat_ok, tag, 32'(pa), 32'(pe));
        chk(done_ok, "R11 done timing", 32'(done), 32'(1));
        chk(excl_ok, "R12 exclusivity", 32'(0), 32'(1));
        if (typ != 0 && typ <= 5) chk(addr_ok, {tag, " addr"}, 32'(aa), 32'(ae));
        if (typ == 3 || typ == 5) chk(dout_ok, "R5 dout", 32'(dout), 32'(wd));
        if (typ == 1) begin
            chk(rf_ok, "R3 refresh", 32'(ra), 32'(re));
            rcnt_model = (rcnt_model + 1) % 128;
        end
        if (typ == 1 || typ == 2 || typ == 4)
            chk(rdata === (dv ? dval : 8'hFF), "R8 rdata", 32'(rdata),
                32'(dv ? dval : 8'hFF));
        if (typ == 0 || typ > 5)
            chk(pat_ok && done_ok, "R9 internal", 32'(pat_ok), 32'(1));
    endtask

    task automatic test_reset();
        chk(req_ready && busack_n && bus_oe && !done && mreq_n && iorq_n && rd_n &&
            wr_n && m1_n && rfsh_n, "R1 reset state",
            32'({req_ready, busack_n, bus_oe, done, mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n}),
            32'(10'b1110111111));
    endtask

    task automatic test_grant_idle();
        busreq_n = 1'b0;
        @(negedge clk);
        chk(!busack_n && !bus_oe && !req_ready, "R10 grant",
            32'({busack_n, bus_oe, req_ready}), 32'(0));
        req_type = 3'd2; req_valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(mreq_n && rd_n && !busack_n, "R10 request ignored",
                32'({mreq_n, rd_n, busack_n}), 32'(3'b110));
        end
        req_valid = 1'b0;
        busreq_n = 1'b1;
        @(negedge clk);
        chk(busack_n && bus_oe && req_ready && mreq_n, "R10 release",
            32'({busack_n, bus_oe, req_ready, mreq_n}), 32'(4'b1111));
    endtask

    task automatic test_grant_mid();
        run_cycle(2, 16'h1357, 8'h00, 0, 1'b1, 8'h42, 1'b1, "R10 read under busreq");
        chk(busack_n === 1'b1 && req_ready === 1'b0, "R10 deferred grant",
            32'({busack_n, req_ready}), 32'(2'b10));
        @(negedge clk);
        chk(busack_n === 1'b0 && bus_oe === 1'b0, "R10 grant after done",
            32'({busack_n, bus_oe}), 32'(0));
        busreq_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R11 actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_cycle(1, 16'h0100, 8'h00, 0, 1'b1, 8'hC3, 1'b0, "R2 fetch");
        run_cycle(2, 16'h8001, 8'h00, 0, 1'b1, 8'h5A, 1'b0, "R4 read");
        run_cycle(2, 16'h8002, 8'h00, 0, 1'b0, 8'h12, 1'b0, "R8 undriven read");
        run_cycle(3, 16'h4000, 8'h99, 1, 1'b0, 8'h00, 1'b0, "R5 write");
        run_cycle(3, 16'h4001, 8'h66, 0, 1'b0, 8'h00, 1'b0, "R5 write no wait");
        run_cycle(4, 16'h00FE, 8'h00, 0, 1'b1, 8'hA5, 1'b0, "R6 input");
        run_cycle(5, 16'h00FD, 8'h3E, 2, 1'b0, 8'h00, 1'b0, "R6 output");
        run_cycle(2, 16'hC000, 8'h00, 3, 1'b1, 8'h81, 1'b0, "R7 read waits");
        run_cycle(1, 16'h0101, 8'h00, 1, 1'b0, 8'h00, 1'b0, "R7 fetch wait");
        run_cycle(1, 16'h0102, 8'h00, 0, 1'b1, 8'h01, 1'b0, "R3 second fetch");
        run_cycle(0, 16'h0000, 8'h00, 0, 1'b0, 8'h00, 1'b0, "R9 internal");
        run_cycle(7, 16'h0000, 8'h00, 0, 1'b0, 8'h00, 1'b0, "R9 unused code");
        chk(rdata === 8'h01, "R8 rdata holds", 32'(rdata), 32'h01);
        test_grant_idle();
        test_grant_mid();
        run_cycle(4, 16'h0010, 8'h00, 1, 1'b0, 8'h00, 1'b0, "R6 input wait");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule